// File: doc/BRIEF.md
# IDE Bus-Master Register Bank with Interrupt Combiner

This block holds the byte-wide bus-master registers of a two-channel PCI IDE controller and merges the interrupt requests of both channels into one level-sensitive PCI interrupt line. A simple register port writes and reads one byte per access. It selects the channel with `chan_sel` and the register with `reg_off`, which is the low two bits of the I/O address. Offset 0 is the command byte, offset 1 the shared mode byte, offset 2 the channel status byte and offset 3 the channel timing byte. Reads come straight from the stored state and have no side effects.

A strap input, `ext_type`, selects one of two controller types. The basic type implements only command and status. The extended type adds three things: a mode byte shared by both channels, which latches one interrupt flag and one blocking mask per channel; a timing byte per channel; and an interrupt line driven by the flags that are not blocked. The DMA engine reports activity and errors into the status bytes and uses the start and direction bits of the command bytes. Each channel's drive logic supplies a request level and its interrupt-disable control bit.

Top module: `ide_bm_regs`

## Requirements
- R1: After reset, every command, status, mode and timing byte reads as 0x00 (offsets 1 and 3 read 0xFF in the basic type), and `irq_out` is low.
- R2: A write to offset 0 stores bit 0 (start) and bit 3 (direction, 1 = write to memory) of the selected channel. All other command bits read as 0. `dma_start` and `dma_dir` present the stored bits.
- R3: Status at offset 2 behaves as follows. Bits 6:5 take the written value. Bits 2:1 are write-one-to-clear. Bit 0 follows `dma_busy` one clock late, and a write does not change it. `dma_err` sets bit 1. Bits 7, 4 and 3 always read as 0.
- R4: When `ext_type` is 0, reads of offsets 1 and 3 return 0xFF and writes to those offsets have no effect.
- R5: When `ext_type` is 1, a write to offset 1 changes only mode bits 5:4 (bit 4 blocks channel 0, bit 5 blocks channel 1). Mode bits 1:0 and 7:6 always read as 0. Both channels read the same mode byte.
- R6: When `ext_type` is 1, offset 3 reads and writes a separate 8-bit timing byte for each channel.
- R7: A rising `chan_req[c]` sets mode bit 2+c and status bit 2 of channel c. A falling `chan_req[c]` clears only mode bit 2+c. If a rise and a status write land in the same cycle, the rise wins.
- R8: A rise of `chan_req[c]` while `chan_irq_off[c]` is high sets neither the flag nor the status bit.
- R9: In the extended type, `irq_out` equals (mode[2] AND NOT mode[4]) OR (mode[3] AND NOT mode[5]). It is registered and reflects the mode byte as updated at the same clock edge.
- R10: In the basic type, `irq_out` is the registered OR over both channels of `chan_req & ~chan_irq_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_type | input | 1 | Controller type strap, 1 = extended |
| wr_en | input | 1 | Write strobe for one byte |
| chan_sel | input | 1 | Channel addressed by the access |
| reg_off | input | 2 | Register offset within the channel window |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| chan_req | input | 2 | Interrupt request level per channel |
| chan_irq_off | input | 2 | Drive interrupt-disable control bit per channel |
| dma_busy | input | 2 | DMA engine active per channel |
| dma_err | input | 2 | DMA error pulse per channel |
| dma_start | output | 2 | Stored start bit per channel |
| dma_dir | output | 2 | Stored direction bit per channel |
| irq_out | output | 1 | Level-sensitive PCI interrupt |

## Verification
The hardest case to reach from the ports is a collision at a single clock edge: a request edge arrives together with a write that clears the same status bit or changes the blocking mask that gates it. A write-one-to-clear of status bit 2 must lose to a fresh request, and a mask write must not disturb the flags. Directed sequences line these events up on purpose. Random stimulus flips the request, disable, busy and error inputs at moderate rates under both strap settings, so that edges often meet register writes. After every clock edge the bench reads all eight registers and compares them, together with the interrupt and command outputs, against a bench model of the requirements.

// File: rtl/ide_bm_regs.sv
module ide_bm_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_type,
  input  logic       wr_en,
  input  logic       chan_sel,
  input  logic [1:0] reg_off,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [1:0] chan_req,
  input  logic [1:0] chan_irq_off,
  input  logic [1:0] dma_busy,
  input  logic [1:0] dma_err,
  output logic [1:0] dma_start,
  output logic [1:0] dma_dir,
  output logic       irq_out
);

  localparam logic [1:0] OFF_CMD  = 2'd0;
  localparam logic [1:0] OFF_MODE = 2'd1;
  localparam logic [1:0] OFF_STS  = 2'd2;
  localparam logic [1:0] OFF_TIM  = 2'd3;

  logic [7:0] cmd_q [2];
  logic [7:0] sts_q [2];
  logic [7:0] sts_d [2];
  logic [7:0] tim_q [2];
  logic [7:0] mode_q, mode_d;
  logic [1:0] req_q, rise, fall;
  logic       irq_d;

  wire wr_cmd  = wr_en && reg_off == OFF_CMD;
  wire wr_mode = wr_en && reg_off == OFF_MODE && ext_type;
  wire wr_sts  = wr_en && reg_off == OFF_STS;
  wire wr_tim  = wr_en && reg_off == OFF_TIM && ext_type;

  assign rise = chan_req & ~req_q & ~chan_irq_off;
  assign fall = ~chan_req & req_q;

  always_comb begin
    mode_d = mode_q;
    if (wr_mode) mode_d[5:4] = wr_data[5:4];
    for (int c = 0; c < 2; c++) begin
      if (rise[c])      mode_d[2+c] = 1'b1;
      else if (fall[c]) mode_d[2+c] = 1'b0;
    end
    irq_d = ext_type ? ((mode_d[2] & ~mode_d[4]) | (mode_d[3] & ~mode_d[5]))
                     : |(chan_req & ~chan_irq_off);
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      sts_d[c]    = sts_q[c] & 8'h66;
      sts_d[c][0] = dma_busy[c];
      if (wr_sts && chan_sel == c[0]) begin
        sts_d[c][6:5] = wr_data[6:5];
        sts_d[c][2:1] = sts_q[c][2:1] & ~wr_data[2:1];
      end
      if (dma_err[c]) sts_d[c][1] = 1'b1;
      if (rise[c])    sts_d[c][2] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        cmd_q[c] <= '0;
        sts_q[c] <= '0;
        tim_q[c] <= '0;
      end
      mode_q  <= '0;
      req_q   <= '0;
      irq_out <= 1'b0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        sts_q[c] <= sts_d[c];
        if (wr_cmd && chan_sel == c[0]) cmd_q[c] <= wr_data & 8'h09;
        if (wr_tim && chan_sel == c[0]) tim_q[c] <= wr_data;
      end
      mode_q  <= mode_d;
      req_q   <= chan_req;
      irq_out <= irq_d;
    end
  end

  always_comb begin
    case (reg_off)
      OFF_CMD:  rd_data = cmd_q[chan_sel];
      OFF_MODE: rd_data = ext_type ? mode_q : 8'hFF;
      OFF_STS:  rd_data = sts_q[chan_sel];
      default:  rd_data = ext_type ? tim_q[chan_sel] : 8'hFF;
    endcase
  end

  assign dma_start = {cmd_q[1][0], cmd_q[0][0]};
  assign dma_dir   = {cmd_q[1][3], cmd_q[0][3]};

  AST_STS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q[0] | sts_q[1]) & 8'h98) == 8'h00); // R3
  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts && wr_data[2] && !rise[chan_sel] |=> !sts_q[$past(chan_sel)][2]); // R3
  AST_BASIC_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_type && reg_off[0] |-> rd_data == 8'hFF); // R4
  AST_MODE_WR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode && chan_req == req_q |=> mode_q[3:2] == $past(mode_q[3:2])); // R5
  AST_FALL_KEEPS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    fall[0] && !(wr_sts && !chan_sel) |=> sts_q[0][2] == $past(sts_q[0][2])); // R7
  AST_GATED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_req[0] && !req_q[0] && chan_irq_off[0] && !mode_q[2] |=> !mode_q[2]); // R8
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_type && rise[0] && !mode_q[4] && !(wr_mode && wr_data[4]) |=> irq_out); // R9

endmodule

// File: tb/ide_bm_regs_bench.sv
`timescale 1ns/100ps
module ide_bm_regs_bench;
  logic       clk = 0, rst_n = 0, ext_type = 0, wr_en = 0, chan_sel = 0;
  logic [1:0] reg_off = 0, chan_req = 0, chan_irq_off = 0, dma_busy = 0, dma_err = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [1:0] dma_start, dma_dir;
  logic       irq_out;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_cmd [2], m_sts [2], m_tim [2];
  logic [7:0] m_mode;
  logic [1:0] m_reqp;
  logic       m_irq;

  always #5 clk = ~clk;

  ide_bm_regs u_ide_bm_regs (.*);

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic ch, logic [1:0] off);
    case (off)
      2'd0: return m_cmd[ch];
      2'd1: return ext_type ? m_mode : 8'hFF;
      2'd2: return m_sts[ch];
      default: return ext_type ? m_tim[ch] : 8'hFF;
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_sts[c] = 0; m_tim[c] = 0;
    end
    m_mode = 0; m_reqp = 0; m_irq = 0;
  endtask

  task automatic check_all();
    string tags [4] = '{"R2 cmd", "R5 mode", "R3 sts", "R6 tim"};
    wr_en = 0;
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 4; o++) begin
        chan_sel = c[0]; reg_off = o[1:0];
        #0.5;
        chk(ext_type ? tags[o] : (o[0] ? "R4 basic" : tags[o]), rd_data, exp_rd(c[0], o[1:0]));
      end
    chk(ext_type ? "R9 irq" : "R10 irq", {7'd0, irq_out}, {7'd0, m_irq});
    chk("R2 outs", {4'd0, dma_dir, dma_start},
        {4'd0, m_cmd[1][3], m_cmd[0][3], m_cmd[1][0], m_cmd[0][0]});
  endtask

  task automatic step(logic wr, logic ch, logic [1:0] off, logic [7:0] d,
                      logic [1:0] req, logic [1:0] ioff, logic [1:0] busy, logic [1:0] err);
    logic [1:0] rise, fall;
    wr_en = wr; chan_sel = ch; reg_off = off; wr_data = d;
    chan_req = req; chan_irq_off = ioff; dma_busy = busy; dma_err = err;
    @(posedge clk);
    rise = req & ~m_reqp & ~ioff;
    fall = ~req & m_reqp;
    for (int c = 0; c < 2; c++) begin
      logic [7:0] s;
      s = m_sts[c] & 8'h66;
      s[0] = busy[c];
      if (wr && off == 2 && ch == c[0]) begin
        s[6:5] = d[6:5];
        s[2:1] = m_sts[c][2:1] & ~d[2:1];
      end
      if (err[c]) s[1] = 1;
      if (rise[c]) s[2] = 1;
      m_sts[c] = s;
      if (wr && off == 0 && ch == c[0]) m_cmd[c] = d & 8'h09;
      if (ext_type && wr && off == 3 && ch == c[0]) m_tim[c] = d;
    end
    if (ext_type && wr && off == 1) m_mode[5:4] = d[5:4];
    for (int c = 0; c < 2; c++) begin
      if (rise[c]) m_mode[2+c] = 1;
      else if (fall[c]) m_mode[2+c] = 0;
    end
    m_irq = ext_type ? ((m_mode[2] & ~m_mode[4]) | (m_mode[3] & ~m_mode[5]))
                     : |(req & ~ioff);
    m_reqp = req;
    #2;
    check_all();
  endtask

  task automatic do_reset(logic ext);
    rst_n = 0; ext_type = ext; wr_en = 0;
    chan_req = 0; chan_irq_off = 0; dma_busy = 0; dma_err = 0;
    repeat (3) @(posedge clk);
    model_reset();
    #2;
    check_all(); // R1
    rst_n = 1;
  endtask

  initial begin
    logic [1:0] rq, io;
    void'($urandom(32'd1234));
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(pass[0]);
      rq = 0; io = 0;
      // R3 R7: request rise meets a clearing write of the same status bit
      step(1, 0, 2, 8'h64, 2'b00, 2'b00, 2'b00, 2'b10);
      step(1, 0, 2, 8'h04, 2'b01, 2'b00, 2'b01, 2'b00);
      step(1, 0, 2, 8'h06, 2'b01, 2'b00, 2'b00, 2'b00);
      // R5 R9: mask write together with a request on channel 1
      step(1, 1, 1, 8'hFF, 2'b11, 2'b00, 2'b00, 2'b00);
      step(1, 0, 1, 8'h00, 2'b10, 2'b00, 2'b00, 2'b00);
      // R8: rise while disabled, then release
      step(0, 0, 0, 8'h00, 2'b00, 2'b01, 2'b00, 2'b00);
      step(0, 0, 0, 8'h00, 2'b01, 2'b01, 2'b00, 2'b00);
      step(0, 0, 0, 8'h00, 2'b01, 2'b00, 2'b00, 2'b00);
      // R2 R6 R4: command and timing writes
      step(1, 1, 0, 8'hFF, 2'b00, 2'b00, 2'b00, 2'b00);
      step(1, 0, 3, 8'hA5, 2'b00, 2'b00, 2'b00, 2'b00);
      step(1, 1, 3, 8'h3C, 2'b00, 2'b00, 2'b00, 2'b00);
      for (int i = 0; i < 400; i++) begin
        if ($urandom % 4 == 0) rq[$urandom % 2] ^= 1'b1;
        if ($urandom % 6 == 0) io[$urandom % 2] ^= 1'b1;
        step($urandom % 2 == 0, 1'($urandom), 2'($urandom), 8'($urandom),
             rq, io, 2'($urandom), ($urandom % 8 == 0) ? 2'($urandom) : 2'b00);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule